// File: doc/BRIEF.md
# Burst Read Prefetch Buffer

This block sits between a bus-side read/write request port and the read path of an SDRAM controller. It keeps a small number of line buffers (two by default). Each buffer holds one full SDRAM burst, the burst-aligned tag of that burst, and one valid bit per word. Every read request is compared against all buffers in parallel. A hit returns the stored word on the next cycle and sends nothing to the SDRAM side. A miss stalls the bus, requests the burst that contains the address, and fills one buffer from the returning beats. The requested word goes straight to the bus in the cycle it arrives.

Fills rotate through the buffers in a fixed order, so the buffer filled longest ago is the one replaced. A write request is accepted at once. It produces no response. If the written word is held in a buffer, that word's valid bit is cleared, so a later read fetches fresh data from SDRAM. The block therefore acts as a tiny prefetch cache that uses spatial locality in sequential read streams.

Addresses are word addresses. A burst covers `BURST` consecutive words, starting at an address whose low log2(`BURST`) bits are zero.

Top module: `rdpf_buffer`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_req` is 0, and every buffer is empty, so the first read of any address is a miss.
- R2: A read whose burst tag matches a buffer, and whose word valid bit in that buffer is set, is a hit. `rsp_valid` is 1 in the cycle after acceptance, with the stored word on `rsp_data`, and `mem_req` is not raised.
- R3: On a read miss, `mem_req` rises in the cycle after acceptance, with `mem_addr` equal to the request address with its low log2(`BURST`) bits cleared. Both stay stable until the cycle in which `mem_ack` is 1.
- R4: On a miss, the requested word is presented on `rsp_data` with `rsp_valid` = 1 in the same cycle that it is on `mem_rdata` with `mem_rvalid` = 1. The burst returns in order from the aligned base, one word per `mem_rvalid` cycle.
- R5: All `BURST` words of a fetched burst are stored, so later reads of any word of that burst hit.
- R6: Successive fills go to buffer 0, 1, …, `LINES`-1 and then back to 0. With two buffers, a third distinct burst replaces the first one fetched, while the second stays resident.
- R7: `req_ready` is 0 from the cycle after a miss is accepted until the cycle after the last burst beat. No `mem_req` is raised while `req_ready` is 1.
- R8: A write to a word held in a buffer clears only that word's valid bit. Other words of the same burst still hit. A write to an address held in no buffer changes no buffer state.
- R9: A write request is accepted in one cycle and produces no response. A buffer chosen for a refill loses all its old valid bits when the fill begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | 1 = write (invalidate only), 0 = read |
| req_addr | input | AW | Word address of the request |
| req_ready | output | 1 | Request accepted when high with req_valid |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | DW | Read data |
| mem_req | output | 1 | Burst read request to SDRAM side |
| mem_addr | output | AW | Burst-aligned word address of the request |
| mem_ack | input | 1 | SDRAM side accepted the burst request |
| mem_rvalid | input | 1 | Burst beat valid |
| mem_rdata | input | DW | Burst beat data |

## Verification
A stale valid bit shows up as a hit that returns data from an older epoch of memory, one cycle after the read is accepted. It never produces a mismatch on the SDRAM side. For this reason the directed tests change the memory contents on every write and compare each read against the epoch expected for it. A wrong tag or wrong alternation pointer shows up only on the next read of the affected bursts. Depending on the fault, it appears as an extra or a missing `mem_req` at that point. The tests therefore count SDRAM requests around every read. An off-by-one error in the beat counter or in the stored offset shows up as a response that is either missing or sent on the wrong beat, in the same cycle as that beat.

// File: rtl/rdpf_pkg.sv
package rdpf_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_DATA = 2'd2
   } fill_state_e;

endpackage

// File: rtl/rdpf_line.sv
module rdpf_line #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int BURST = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [AW-1:0]               look_addr,
   input  logic                        fill_start,
   input  logic [AW-$clog2(BURST)-1:0] fill_tag,
   input  logic                        fill_we,
   input  logic [$clog2(BURST)-1:0]    fill_idx,
   input  logic [DW-1:0]               fill_data,
   input  logic                        inv_en,
   input  logic [AW-1:0]               inv_addr,
   output logic                        hit,
   output logic [DW-1:0]               rd_data
);
   localparam int OFFW = $clog2(BURST);
   localparam int TW   = AW - OFFW;

   logic [TW-1:0]    tag_q;
   logic [BURST-1:0] vld_q;
   logic [DW-1:0]    words_q [BURST];

   logic [OFFW-1:0] look_off;
   logic [OFFW-1:0] inv_off;
   logic            inv_match;

   assign look_off  = look_addr[OFFW-1:0];
   assign inv_off   = inv_addr[OFFW-1:0];
   assign inv_match = inv_en && (inv_addr[AW-1:OFFW] == tag_q);

   assign hit     = (look_addr[AW-1:OFFW] == tag_q) && vld_q[look_off];
   assign rd_data = words_q[look_off];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tag_q <= '0;
         vld_q <= '0;
      end else if (fill_start) begin
         tag_q <= fill_tag;
         vld_q <= '0;
      end else begin
         if (fill_we)   vld_q[fill_idx] <= 1'b1;
         if (inv_match) vld_q[inv_off]  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_we) words_q[fill_idx] <= fill_data;
   end

endmodule

// File: rtl/rdpf_fill_ctl.sv
module rdpf_fill_ctl
   import rdpf_pkg::*;
#(
   parameter int BURST = 4
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start,
   input  logic                     mem_ack,
   input  logic                     mem_rvalid,
   output logic                     mem_req,
   output logic                     busy,
   output logic                     beat_we,
   output logic [$clog2(BURST)-1:0] beat_idx
);
   localparam int OFFW = $clog2(BURST);
   localparam logic [OFFW-1:0] LAST_BEAT = OFFW'(BURST - 1);

   fill_state_e     state_q;
   logic [OFFW-1:0] beat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         beat_q  <= '0;
      end else begin
         unique case (state_q)
            FS_IDLE: if (start) state_q <= FS_REQ;
            FS_REQ: if (mem_ack) begin
               state_q <= FS_DATA;
               beat_q  <= '0;
            end
            FS_DATA: if (mem_rvalid) begin
               beat_q <= beat_q + 1'b1;
               if (beat_q == LAST_BEAT) state_q <= FS_IDLE;
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign mem_req  = (state_q == FS_REQ);
   assign busy     = (state_q != FS_IDLE);
   assign beat_we  = (state_q == FS_DATA) && mem_rvalid;
   assign beat_idx = beat_q;

endmodule

// File: rtl/rdpf_buffer.sv
module rdpf_buffer #(
   parameter int AW    = 16,
   parameter int DW    = 32,
   parameter int BURST = 4,
   parameter int LINES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          rsp_valid,
   output logic [DW-1:0] rsp_data,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   input  logic          mem_ack,
   input  logic          mem_rvalid,
   input  logic [DW-1:0] mem_rdata
);
   localparam int OFFW = $clog2(BURST);
   localparam int TW   = AW - OFFW;
   localparam int PW   = (LINES > 1) ? $clog2(LINES) : 1;

   generate
      if (BURST < 2 || (BURST & (BURST - 1)) != 0) begin : g_bad_burst
         $error("rdpf_buffer: BURST must be a power of two >= 2");
      end
      if (LINES < 2) begin : g_bad_lines
         $error("rdpf_buffer: LINES must be at least 2");
      end
      if (AW <= OFFW) begin : g_bad_aw
         $error("rdpf_buffer: AW must exceed log2(BURST)");
      end
   endgenerate

   logic            busy;
   logic            beat_we;
   logic [OFFW-1:0] beat_idx;

   logic [LINES-1:0] hit_vec;
   logic [DW-1:0]    line_data [LINES];
   logic             hit_any;
   logic [DW-1:0]    hit_word;

   logic            accept, rd_hit, rd_miss, wr_inv;
   logic [PW-1:0]   ptr_q, tgt_q;
   logic [TW-1:0]   tag_q;
   logic [OFFW-1:0] off_q;
   logic            hit_q;
   logic [DW-1:0]   hit_data_q;
   logic            fwd;

   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign rd_hit    = accept && !req_write && hit_any;
   assign rd_miss   = accept && !req_write && !hit_any;
   assign wr_inv    = accept && req_write;

   genvar gi;
   generate
      for (gi = 0; gi < LINES; gi++) begin : g_line
         rdpf_line #(.AW(AW), .DW(DW), .BURST(BURST)) u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .look_addr  (req_addr),
            .fill_start (rd_miss && (ptr_q == PW'(gi))),
            .fill_tag   (req_addr[AW-1:OFFW]),
            .fill_we    (beat_we && (tgt_q == PW'(gi))),
            .fill_idx   (beat_idx),
            .fill_data  (mem_rdata),
            .inv_en     (wr_inv),
            .inv_addr   (req_addr),
            .hit        (hit_vec[gi]),
            .rd_data    (line_data[gi])
         );
      end
   endgenerate

   always_comb begin
      hit_word = '0;
      for (int i = LINES - 1; i >= 0; i--) begin
         if (hit_vec[i]) hit_word = line_data[i];
      end
   end
   assign hit_any = |hit_vec;

   rdpf_fill_ctl #(.BURST(BURST)) u_fill (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (rd_miss),
      .mem_ack    (mem_ack),
      .mem_rvalid (mem_rvalid),
      .mem_req    (mem_req),
      .busy       (busy),
      .beat_we    (beat_we),
      .beat_idx   (beat_idx)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q      <= '0;
         tgt_q      <= '0;
         tag_q      <= '0;
         off_q      <= '0;
         hit_q      <= 1'b0;
         hit_data_q <= '0;
      end else begin
         hit_q <= rd_hit;
         if (rd_hit) hit_data_q <= hit_word;
         if (rd_miss) begin
            tgt_q <= ptr_q;
            tag_q <= req_addr[AW-1:OFFW];
            off_q <= req_addr[OFFW-1:0];
            ptr_q <= (ptr_q == PW'(LINES - 1)) ? '0 : ptr_q + 1'b1;
         end
      end
   end

   assign fwd       = beat_we && (beat_idx == off_q);
   assign rsp_valid = hit_q || fwd;
   assign rsp_data  = fwd ? mem_rdata : hit_data_q;
   assign mem_addr  = {tag_q, {OFFW{1'b0}}};

endmodule

// File: rtl/rdpf_buffer_chk.sv
module rdpf_buffer_chk #(
   parameter int AW    = 16,
   parameter int BURST = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_write,
   input logic          req_ready,
   input logic          rsp_valid,
   input logic          mem_req,
   input logic [AW-1:0] mem_addr,
   input logic          mem_ack,
   input logic          mem_rvalid
);
   localparam int OFFW = $clog2(BURST);

   p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

   p_mem_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> (mem_addr[OFFW-1:0] == '0));

   p_read_outcome_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && !req_write |=> rsp_valid || !req_ready);

   p_no_req_when_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> !mem_req);

   p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready && req_write |=> !rsp_valid);

   p_fwd_on_beat_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid && !req_ready |-> mem_rvalid);

endmodule

bind rdpf_buffer rdpf_buffer_chk #(.AW(AW), .BURST(BURST)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_write  (req_write),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .mem_req    (mem_req),
   .mem_addr   (mem_addr),
   .mem_ack    (mem_ack),
   .mem_rvalid (mem_rvalid)
);

// File: tb/rdpf_buffer_bench.sv
module rdpf_buffer_bench;
   localparam int AW    = 16;
   localparam int DW    = 32;
   localparam int BURST = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic          req_ready, rsp_valid, mem_req;
   logic [DW-1:0] rsp_data;
   logic [AW-1:0] mem_addr;
   logic          mem_ack = 1'b0;
   logic          mem_rvalid = 1'b0;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int failures = 0;
   int epoch = 0;
   int mem_reqs = 0;
   logic [AW-1:0] last_mem_addr = '0;
   int rsp_cnt = 0;
   logic [DW-1:0] rsp_last = '0;
   logic rsp_on_beat = 1'b0;
   int ack_delay = 1;
   int beat_gap = 0;

   always #4 clk = ~clk;

   rdpf_buffer #(.AW(AW), .DW(DW), .BURST(BURST), .LINES(2)) u_rdpf_buffer (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .rsp_valid(rsp_valid),
      .rsp_data(rsp_data), .mem_req(mem_req), .mem_addr(mem_addr),
      .mem_ack(mem_ack), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [DW-1:0] mdata(int ep, logic [AW-1:0] a);
      return {ep[7:0], 8'h3C, a};
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // SDRAM-side model: acknowledges, then returns the burst in order
   initial begin
      forever begin
         @(negedge clk);
         if (mem_req) begin
            mem_reqs++;
            last_mem_addr = mem_addr;
            repeat (ack_delay - 1) @(negedge clk);
            mem_ack = 1'b1;
            @(negedge clk);
            mem_ack = 1'b0;
            for (int b = 0; b < BURST; b++) begin
               repeat (beat_gap) @(negedge clk);
               mem_rvalid = 1'b1;
               mem_rdata  = mdata(epoch, last_mem_addr + AW'(b));
               @(negedge clk);
               mem_rvalid = 1'b0;
            end
         end
      end
   end

   // Response monitor, sampled after the falling edge
   always @(negedge clk) begin
      #1;
      if (rsp_valid) begin
         rsp_cnt++;
         rsp_last = rsp_data;
         rsp_on_beat = mem_rvalid;
      end
   end

   task automatic do_read(logic [AW-1:0] a, bit exp_hit, int exp_ep, string req);
      int m0 = mem_reqs;
      int r0 = rsp_cnt;
      int stall = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      #2;
      if (exp_hit) begin
         chk(rsp_cnt == r0 + 1, {req, " hit response after one cycle"}, rsp_cnt - r0, 1);
         chk(rsp_last == mdata(exp_ep, a), {req, " hit data"}, rsp_last, mdata(exp_ep, a));
         chk(mem_reqs == m0, {req, " hit issues no SDRAM request"}, mem_reqs - m0, 0);
      end else begin
         while (!req_ready && stall < 200) begin
            @(negedge clk); #2;
            stall++;
         end
         chk(stall >= BURST, {req, " R7 ready held low during fill"}, stall, BURST);
         chk(mem_reqs == m0 + 1, {req, " R3 miss issues one burst request"}, mem_reqs - m0, 1);
         chk(last_mem_addr == {a[AW-1:2], 2'b00}, {req, " R3 aligned burst address"},
             last_mem_addr, {a[AW-1:2], 2'b00});
         chk(rsp_cnt == r0 + 1, {req, " R4 one forwarded response"}, rsp_cnt - r0, 1);
         chk(rsp_last == mdata(exp_ep, a), {req, " R4 forwarded data"}, rsp_last, mdata(exp_ep, a));
         chk(rsp_on_beat, {req, " R4 response in beat cycle"}, rsp_on_beat, 1);
      end
   endtask

   task automatic do_write(logic [AW-1:0] a, string req);
      int r0 = rsp_cnt;
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_addr = a;
      #2;
      chk(req_ready, {req, " R9 write accepted"}, req_ready, 1);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      epoch++;
      @(negedge clk); #2;
      chk(rsp_cnt == r0, {req, " R9 write gives no response"}, rsp_cnt - r0, 0);
   endtask

   task automatic t_reset;
      #2;
      chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
      chk(rsp_valid == 1'b0, "R1 no response after reset", rsp_valid, 0);
      chk(mem_req == 1'b0, "R1 no mem_req after reset", mem_req, 0);
   endtask

   task automatic t_first_fill;
      do_read(16'h0012, 1'b0, 0, "R1 empty buffers miss");
      do_read(16'h0010, 1'b1, 0, "R5 burst word 0");
      do_read(16'h0011, 1'b1, 0, "R2 burst word 1");
      do_read(16'h0013, 1'b1, 0, "R5 burst word 3");
   endtask

   task automatic t_alternation;
      do_read(16'h0040, 1'b0, 0, "R6 second fill first beat");
      do_read(16'h0012, 1'b1, 0, "R6 first buffer kept");
      beat_gap = 1; ack_delay = 3;
      do_read(16'h0083, 1'b0, 0, "R6 third fill last beat");
      beat_gap = 0; ack_delay = 1;
      do_read(16'h0042, 1'b1, 0, "R6 second buffer kept");
      do_read(16'h0011, 1'b0, 0, "R9 evicted buffer refetched");
      do_read(16'h0081, 1'b1, 0, "R6 third burst resident");
      do_read(16'h0043, 1'b0, 0, "R6 oldest evicted");
   endtask

   task automatic t_invalidate;
      do_write(16'h0012, "R8 cached write");
      do_read(16'h0013, 1'b1, 0, "R8 neighbour still valid");
      do_read(16'h0012, 1'b0, 1, "R8 written word refetched");
      do_write(16'h0200, "R8 uncached write");
      do_read(16'h0041, 1'b1, 0, "R8 uncached write no effect line a");
      do_read(16'h0010, 1'b1, 1, "R8 uncached write no effect line b");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_first_fill();
      t_alternation();
      t_invalidate();
      repeat (4) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(8 * 150000);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule